// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescaler

This block is a watchdog peripheral reached through a small register write/read port. An 8-bit counter advances on a slow tick. The tick comes from a free-running divider: the system clock is divided by a base ratio (512 by default) and then by a further power of two that a 3-bit select chooses. Software keeps the system alive by writing an arming value and then a firing value to the key register. If the counter overflows, the block emits a one-cycle watchdog reset pulse. It does the same when a key value outside the two legal ones is written, or when the control register is written without its mandatory check pattern.

The control register holds the tick select, the check field, a disable bit and a sticky reset-cause flag. The disable bit can be changed only while the external override input is high. A watchdog reset returns the block to its reset state, except that the reset-cause flag is set. The synchronous `rst_n` input marks a power-up or external reset and clears the flag.

The service sequence is a two-state machine. KEY_IDLE moves to KEY_ARMED when 0x55 is written (arm). KEY_ARMED stays in KEY_ARMED when 0x55 is written again (rearm). KEY_ARMED returns to KEY_IDLE when 0xAA is written, which clears the counter (fire), or when any other value is written (abort). KEY_IDLE stays in KEY_IDLE when any value other than 0x55 is written.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_n` is held low at a clock edge, the counter (address 0) reads 0, the control register (address 2) reads 0 and `wd_rst` is low. While the block is enabled, the counter increases by one on each tick.
- R2: A tick occurs every BASE_DIV·2^e clock cycles from a free-running divider, where e = 0 for select codes 0 and 1 and e = code−1 for codes 2 to 7. A new select value applies from the cycle after it is written.
- R3: While the block is enabled, a tick with the counter at 255 sets `wd_rst` high for exactly one cycle, starting in the cycle after that edge. No service clear may occur on the same edge.
- R4: Writing 0x55 to the key register (address 1) arms the sequence, and a further 0x55 keeps it armed. Writing 0xAA while armed clears the counter to 0 and disarms. Writing 0xAA while not armed has no effect and causes no reset.
- R5: Writing any key value other than 0x55 or 0xAA while the block is enabled sets `wd_rst` high in the next cycle.
- R6: A control write whose bits [5:3] are not 101 is discarded, leaving every field unchanged. If the block is enabled, the write also raises `wd_rst` in the next cycle.
- R7: The disable bit is control bit 6, and a valid control write changes it only while `override_en` is 1. While the bit is 1, the counter does not advance and `wd_rst` stays low, although a service clear still sets the counter to 0.
- R8: The reset-cause flag is control bit 7. It is set by every watchdog reset, cleared by `rst_n`, cleared by a valid control write with bit 7 equal to 1, and left unchanged by a write with bit 7 equal to 0.
- R9: The control register reads as {8'h00, flag, disable, 3'b000, select[2:0]}. The key register and address 3 read 0, and the counter reads as {8'h00, count}.
- R10: A watchdog reset clears the counter, the divider, the select, the disable bit and the key sequence. Any write presented while `wd_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up/external reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 counter, 1 key, 2 control |
| wdata | input | 16 | Write data |
| override_en | input | 1 | Allows the disable bit to be changed |
| rdata | output | 16 | Read data for `addr`, combinational |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The counter is observed at several select codes, including the duplicate codes 0 and 1 and a switch in the middle of a run, which shows whether the tick period and the point where a change takes effect are right. Key traffic mixes an unarmed 0xAA, repeated 0x55 writes, a proper 0x55/0xAA pair and illegal values; these separate a correct service from an ignored write and from a forced reset. Control writes with good and bad check patterns, with the override input high and low and with the block enabled and disabled, show whether reset is gated by the disable bit and whether discarded writes really leave the fields alone. A full run to overflow, a pair of writes on consecutive cycles where the second lands on the reset pulse, and an external reset after a watchdog reset exercise the pulse width, the restored state and the setting and clearing of the sticky flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_KEY   = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_SPARE = 2'd3
    } wdt_addr_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    localparam logic [7:0] KEY_ARM_VAL  = 8'h55;
    localparam logic [7:0] KEY_FIRE_VAL = 8'hAA;
    localparam logic [2:0] CHK_PATTERN  = 3'b101;

    localparam int SEL_LSB  = 0;
    localparam int CHK_LSB  = 3;
    localparam int DIS_BIT  = 6;
    localparam int FLAG_BIT = 7;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int BASE_DIV = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int BW      = $clog2(BASE_DIV);
    localparam int MAX_EXP = 6;
    localparam int PW      = BW + MAX_EXP;

    logic [PW-1:0]    div_q;
    logic [MAX_EXP:0] tick_opt;
    logic [2:0]       exp_sel;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // one candidate tick per power-of-two stretch of the base period
    for (genvar k = 0; k <= MAX_EXP; k++) begin : g_opt
        assign tick_opt[k] = &div_q[BW+k-1:0];
    end

    always_comb begin
        exp_sel = (sel < 3'd2) ? 3'd0 : (sel - 3'd1);
        tick    = tick_opt[exp_sel];
    end

    // R2: the base period is at least two cycles, so ticks never touch
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       svc_clear,
    output logic       key_bad
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (key_val == KEY_ARM_VAL) state_d = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (key_val == KEY_ARM_VAL) state_d = KEY_ARMED;
                    else                        state_d = KEY_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        svc_clear = key_wr && (state_q == KEY_ARMED) && (key_val == KEY_FIRE_VAL);
        key_bad   = key_wr && (key_val != KEY_ARM_VAL) && (key_val != KEY_FIRE_VAL);
    end

    assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY_ARM_VAL && !soft_rst) |=> state_q == KEY_ARMED);

    assert_fire_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY_FIRE_VAL && !soft_rst) |=> state_q == KEY_IDLE);

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       ctrl_wr,
    input  logic [7:0] wbyte,
    input  logic       override_en,
    output logic [2:0] sel_q,
    output logic       dis_q,
    output logic       flag_q,
    output logic       chk_bad
);
    always_comb begin
        chk_bad = ctrl_wr && (wbyte[CHK_LSB+2:CHK_LSB] != CHK_PATTERN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 3'd0;
            dis_q  <= 1'b0;
            flag_q <= 1'b0;
        end else if (soft_rst) begin
            sel_q  <= 3'd0;
            dis_q  <= 1'b0;
            flag_q <= 1'b1;
        end else if (ctrl_wr && !chk_bad) begin
            sel_q <= wbyte[SEL_LSB+2:SEL_LSB];
            if (override_en)     dis_q  <= wbyte[DIS_BIT];
            if (wbyte[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !soft_rst) |=> flag_q == $past(flag_q));

    assert_dis_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!override_en && !soft_rst) |=> dis_q == $past(dis_q));

    assert_bad_chk_discarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_bad && !soft_rst) |=> (sel_q == $past(sel_q)) && (dis_q == $past(dis_q)));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int BASE_DIV = 512,
    parameter int CNT_W    = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              override_en,
    output logic [DATA_W-1:0] rdata,
    output logic              wd_rst
);
    logic [CNT_W-1:0] cnt_q;
    logic             wd_rst_q;
    logic             bus_wr, key_wr, ctrl_wr;
    logic             tick, svc_clear, key_bad, chk_bad;
    logic [2:0]       sel_q;
    logic             dis_q, flag_q, enabled, cnt_max, ovf, trig;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:8];

    always_comb begin
        bus_wr  = wr_en && !wd_rst_q;
        key_wr  = bus_wr && (addr == ADDR_KEY);
        ctrl_wr = bus_wr && (addr == ADDR_CTRL);
    end

    wdt_prescaler #(.BASE_DIV(BASE_DIV)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (trig),
        .sel      (sel_q),
        .tick     (tick)
    );

    wdt_key_fsm u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (trig),
        .key_wr    (key_wr),
        .key_val   (wdata[7:0]),
        .svc_clear (svc_clear),
        .key_bad   (key_bad)
    );

    wdt_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (trig),
        .ctrl_wr     (ctrl_wr),
        .wbyte       (wdata[7:0]),
        .override_en (override_en),
        .sel_q       (sel_q),
        .dis_q       (dis_q),
        .flag_q      (flag_q),
        .chk_bad     (chk_bad)
    );

    always_comb begin
        enabled = !dis_q;
        cnt_max = &cnt_q;
        ovf     = tick && cnt_max && !svc_clear;
        trig    = enabled && (ovf || key_bad || chk_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            wd_rst_q <= 1'b0;
        end else begin
            wd_rst_q <= trig;
            if (trig || svc_clear)    cnt_q <= '0;
            else if (enabled && tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_COUNT: rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            ADDR_KEY:   rdata = '0;
            ADDR_CTRL:  rdata = {{(DATA_W-8){1'b0}}, flag_q, dis_q, 3'b000, sel_q};
            ADDR_SPARE: rdata = '0;
        endcase
        wd_rst = wd_rst_q;
    end

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_q |=> !wd_rst_q);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_q && tick && cnt_q == {CNT_W{1'b1}} && !svc_clear) |=> wd_rst_q);

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_bad && !dis_q) |=> wd_rst_q);

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> !wd_rst_q);

    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !svc_clear) |=> cnt_q == $past(cnt_q));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_q) |-> (cnt_q == '0 && sel_q == 3'd0 && flag_q));

endmodule

// File: tb/wdt_keyed_test.sv
module wdt_keyed_test;
    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic        override_en = 1'b0;
    logic [15:0] rdata;
    logic        wd_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_p, m_ps, m_dis, m_flag, m_armed, m_wdr;

    wdt_keyed #(.BASE_DIV(B)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .override_en(override_en), .rdata(rdata), .wd_rst(wd_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        int e, per, v, chk;
        bit tk, en, t, clr;
        if (!rst_n) begin
            m_cnt = 0; m_p = 0; m_ps = 0; m_dis = 0; m_flag = 0; m_armed = 0; m_wdr = 0;
        end else begin
            e   = (m_ps < 2) ? 0 : m_ps - 1;
            per = B * (1 << e);
            tk  = ((m_p % per) == per - 1);
            en  = (m_dis == 0);
            t = 0; clr = 0;
            v = int'(wdata[7:0]);
            if (wr_en && m_wdr == 0) begin
                if (addr == 2'd1) begin
                    if (v == 'h55) m_armed = 1;
                    else if (v == 'hAA) begin
                        if (m_armed == 1) clr = 1;
                        m_armed = 0;
                    end else begin
                        m_armed = 0;
                        if (en) t = 1;
                    end
                end else if (addr == 2'd2) begin
                    chk = (v >> 3) & 7;
                    if (chk != 5) begin
                        if (en) t = 1;
                    end else begin
                        m_ps = v & 7;
                        if (override_en) m_dis = (v >> 6) & 1;
                        if (((v >> 7) & 1) == 1) m_flag = 0;
                    end
                end
            end
            if (en && tk && m_cnt == 255 && !clr) t = 1;
            if (t) begin
                m_cnt = 0; m_p = 0; m_ps = 0; m_dis = 0; m_armed = 0; m_flag = 1;
            end else begin
                if (clr) m_cnt = 0;
                else if (en && tk) m_cnt = m_cnt + 1;
                m_p = (m_p + 1) % (B * 64);
            end
            m_wdr = t ? 1 : 0;
        end
    end

    function automatic int model_read(input logic [1:0] a);
        if (a == 2'd0) return m_cnt;
        if (a == 2'd2) return (m_flag << 7) | (m_dis << 6) | m_ps;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (wd_rst !== (m_wdr == 1)) begin
                errors++;
                $display("FAIL %s wd_rst actual=%0b expected=%0d t=%0t", cur_req, wd_rst, m_wdr, $time);
            end
            checks++;
            if (rdata !== 16'(model_read(addr))) begin
                errors++;
                $display("FAIL %s rdata[%0d] actual=%h expected=%h t=%0t", cur_req, addr, rdata,
                         16'(model_read(addr)), $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout actual=%0d expected<190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            wr_en = 1'b0; addr = 2'd0;
        end
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [15:0] exp, input string req);
        @(posedge clk); #2;
        wr_en = 1'b0; addr = a;
        #10;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read[%0d] actual=%h expected=%h", req, a, rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1'b1;
        expect_read(2'd2, 16'h0000, "R1 control after reset");
        expect_read(2'd0, 16'h0000, "R1 counter after reset");
        cur_req = "R1"; idle(60);

        cur_req = "R4"; wr(2'd1, 16'h00AA); idle(20);
        wr(2'd1, 16'h0055); wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA); idle(30);

        cur_req = "R5"; wr(2'd1, 16'h0012); idle(1);
        expect_read(2'd2, 16'h0080, "R8 flag set by watchdog reset");
        expect_read(2'd0, 16'h0000, "R10 counter cleared by watchdog reset");

        cur_req = "R8"; wr(2'd2, 16'h0028); idle(1);
        expect_read(2'd2, 16'h0080, "R8 write of 0 leaves flag");
        wr(2'd2, 16'h00A8); idle(1);
        expect_read(2'd2, 16'h0000, "R8 write of 1 clears flag");

        cur_req = "R6"; wr(2'd2, 16'h0003); idle(1);
        expect_read(2'd2, 16'h0080, "R6 bad check resets, select unchanged");
        wr(2'd2, 16'h00A8); idle(5);

        cur_req = "R2"; wr(2'd2, 16'h0029); idle(40);
        wr(2'd2, 16'h002B); idle(200);
        wr(2'd2, 16'h002F); idle(300);
        wr(2'd2, 16'h0028); idle(40);

        cur_req = "R7"; override_en = 1'b0; wr(2'd2, 16'h0068); idle(1);
        expect_read(2'd2, 16'h0000, "R7 disable locked without override");
        override_en = 1'b1; wr(2'd2, 16'h0068); idle(1);
        expect_read(2'd2, 16'h0040, "R7 disable set with override");
        wr(2'd1, 16'h0012); idle(3);
        wr(2'd2, 16'h0041); idle(1);
        expect_read(2'd2, 16'h0040, "R6 bad check discarded while disabled");
        idle(2000);
        wr(2'd1, 16'h0055); wr(2'd1, 16'h00AA); idle(1);
        expect_read(2'd0, 16'h0000, "R7 service clears while disabled");

        cur_req = "R3"; wr(2'd2, 16'h0028); idle(1100);
        expect_read(2'd2, 16'h0080, "R3 overflow caused watchdog reset");

        cur_req = "R8"; @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        expect_read(2'd2, 16'h0000, "R8 external reset clears flag");

        cur_req = "R10"; wr(2'd1, 16'h0099); wr(2'd2, 16'h002D); idle(2);
        expect_read(2'd2, 16'h0080, "R10 write during pulse ignored");

        cur_req = "R9";
        expect_read(2'd1, 16'h0000, "R9 key reads zero");
        expect_read(2'd3, 16'h0000, "R9 spare reads zero");
        idle(5);

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule